// File: doc/BRIEF.md
# Synchronous Serial Character Engine

This block moves characters over a pair of serial data lines that share one serial clock. The serial clock comes from outside and is brought into the system clock domain by a short synchronizer. Every serial clock edge becomes a one-cycle strobe: one edge launches transmit data and the other edge samples receive data. A polarity setting decides which edge does which.

A static format selects the character length, the parity mode, the stop bit count and the clock polarity. It covers all thirty combinations of length, parity and stop count. The transmit side takes a nine-bit character through a valid/ready handshake and sends it as a complete frame. It holds one character in waiting, so back-to-back frames leave no idle bit between them. The receive side finds a start bit on its own. It returns each character with a parity error flag and a frame error flag on a single-cycle valid strobe.

The format inputs are copied into an internal register only while both directions are idle. A host may therefore change them at any time, and a frame in flight keeps the format it started with.

Top module: `sync_frame_engine`

## Requirements
- R1: A transmitted frame opens with one low start bit, followed by the data bits least significant first. The count is set by `cfg_len`: code 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, and 4 or above gives 9. Character bits above the configured length are not sent.
- R2: `cfg_par` selects the parity mode: 0 and 1 mean no parity bit, 2 means even and 3 means odd. When parity is on, one bit follows the last data bit. That bit makes the number of ones across the configured data bits plus the parity bit even (mode 2) or odd (mode 3).
- R3: The frame closes with one high stop bit when `cfg_stop2` is 0, and with two high stop bits when it is 1.
- R4: If a character is waiting when the last stop bit of a frame ends, its start bit follows on the very next launch edge. With nothing waiting, `ser_out` stays high.
- R5: With `cfg_pol` = 0, `ser_out` changes only after a rising `ser_clk` edge and `ser_in` is sampled on falling edges. With `cfg_pol` = 1, the two edges swap roles.
- R6: The receiver starts a frame when it samples `ser_in` low while idle. After the first stop bit it raises `rx_valid` for exactly one cycle. `rx_data` then holds the received bits zero-extended to 9 bits.
- R7: `rx_perr` is 1 with a character whose received parity bit breaks the configured even or odd rule. It is always 0 when parity is off.
- R8: `rx_ferr` is 1 with a character whose first stop bit was sampled low. Only the first stop bit is examined.
- R9: A character is accepted on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` then stays low until that character's start bit is launched.
- R10: Format inputs take effect only while the transmitter (including its waiting character) and the receiver are both idle. A frame in progress keeps its starting format.
- R11: After reset, `ser_out` is high, `tx_ready` is high and `rx_valid` is low. The format is 8 data bits, no parity, one stop bit, polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | 3 | Character length code (0..4 gives 5..9 bits) |
| cfg_par | input | 2 | Parity mode: 0/1 none, 2 even, 3 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_pol | input | 1 | Serial clock polarity |
| ser_clk | input | 1 | Shared serial clock |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a character |
| ser_out | output | 1 | Serial transmit line |
| ser_in | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle strobe with a received character |
| rx_data | output | 9 | Received character, zero-extended |
| rx_perr | output | 1 | Parity error for the delivered character |
| rx_ferr | output | 1 | Frame error for the delivered character |

## Verification
A `ser_clk` edge acts at the third rising `clk` edge after it: two synchronizer stages plus one edge-history flop. Both the `ser_out` change and the `rx_valid` pulse therefore land about three cycles after the serial edge that causes them. The bench reads `ser_out` on its own sampling edge of `ser_clk`, half a serial period after launch, when the line is settled. It reads received characters ten system cycles after the last sampled bit, well beyond the three-cycle latency. `tx_ready` is checked on the first falling `clk` edge after acceptance, where it must already be low.

// File: rtl/sfe_pkg.sv
// Shared types and helpers for the synchronous character engine.
// Assumes a maximum character of nine bits.
package sfe_pkg;

    localparam int MAX_DATA = 9;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_RSVD = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_e;

    typedef struct packed {
        logic [2:0] len_code;
        par_e       par;
        logic       stop2;
        logic       pol;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{len_code: 3'd3, par: PAR_NONE, stop2: 1'b0, pol: 1'b0};

    // Number of data bits for a length code; codes of 4 and above mean nine.
    function automatic logic [3:0] data_bits(input logic [2:0] code);
        return (code >= 3'd4) ? 4'd9 : (4'd5 + {1'b0, code});
    endfunction

    // True when the mode inserts a parity bit.
    function automatic logic par_on(input par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

endpackage

// File: rtl/sfe_edge.sv
// Serial clock edge strobes.
// Brings ser_clk and ser_in into the clk domain through SYNC_STAGES flops.
// Produces one-cycle launch and sample strobes chosen by the polarity bit.
// Assumes ser_clk is slower than clk/4 and SYNC_STAGES >= 2.
module sfe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_in,
    input  logic pol,
    output logic launch_stb,
    output logic sample_stb,
    output logic ser_in_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] clk_sync;
    logic [LAST:0] din_sync;
    logic          clk_prev;
    logic          rise;
    logic          fall;

    // Synchronizer chains and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sync <= '0;
            din_sync <= '1;
            clk_prev <= 1'b0;
        end else begin
            clk_sync <= {clk_sync[LAST-1:0], ser_clk};
            din_sync <= {din_sync[LAST-1:0], ser_in};
            clk_prev <= clk_sync[LAST];
        end
    end

    // Edge decode and role selection by polarity.
    always_comb begin
        rise       = clk_sync[LAST] & ~clk_prev;
        fall       = ~clk_sync[LAST] & clk_prev;
        launch_stb = pol ? fall : rise;
        sample_stb = pol ? rise : fall;
        ser_in_s   = din_sync[LAST];
    end

endmodule

// File: rtl/sfe_tx.sv
// Transmit serializer with a one-character holding slot.
// Builds start, data, parity and stop bits at load time and shifts one bit
// per launch strobe. A waiting character starts right after the last stop bit.
module sfe_tx
    import sfe_pkg::*;
#(
    parameter int DATA_W  = MAX_DATA,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        len_code,
    input  par_e              par,
    input  logic              stop2,
    input  logic              launch_stb,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out,
    output logic              tx_busy
);
    logic              pend_q;
    logic [DATA_W-1:0] pend_d;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  flen;
    logic [3:0]        nb;
    logic              par_en;
    logic              par_acc;

    // Frame image and length for the waiting character.
    always_comb begin
        nb      = data_bits(len_code);
        par_en  = par_on(par);
        par_acc = (par == PAR_ODD);
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nb)) begin
                frame[i+1] = pend_d[i];
                par_acc    = par_acc ^ pend_d[i];
            end
        end
        for (int i = 1; i < FRAME_W; i++) begin
            if (par_en && (i == int'(nb) + 1)) frame[i] = par_acc;
        end
        flen = CNT_W'(nb) + CNT_W'(par_en) + (stop2 ? CNT_W'(3) : CNT_W'(2));
    end

    // Holding slot, shifter and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pend_d  <= '0;
            sh_q    <= '1;
            left_q  <= '0;
            ser_out <= 1'b1;
        end else begin
            if (tx_valid && tx_ready) begin
                pend_q <= 1'b1;
                pend_d <= tx_data;
            end
            if (launch_stb) begin
                if (left_q > CNT_W'(1)) begin
                    sh_q    <= sh_q >> 1;
                    ser_out <= sh_q[1];
                    left_q  <= left_q - CNT_W'(1);
                end else if (pend_q) begin
                    sh_q    <= frame;
                    ser_out <= frame[0];
                    left_q  <= flen;
                    pend_q  <= 1'b0;
                end else begin
                    ser_out <= 1'b1;
                    left_q  <= '0;
                end
            end
        end
    end

    assign tx_ready = ~pend_q;
    assign tx_busy  = pend_q | (left_q != '0);

endmodule

// File: rtl/sfe_rx.sv
// Receive deserializer.
// Waits for a low sample while idle, gathers data bits LSB first and an
// optional parity bit, checks the first stop bit, then pulses rx_valid.
// Assumes ser_in is already synchronized and aligned with sample_stb.
module sfe_rx
    import sfe_pkg::*;
#(
    parameter int DATA_W = MAX_DATA,
    parameter int CNT_W  = $clog2(DATA_W + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        len_code,
    input  par_e              par,
    input  logic              sample_stb,
    input  logic              ser_in_s,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_busy
);
    logic              busy_q;
    logic [CNT_W-1:0]  pos_q;
    logic [DATA_W-1:0] dat_q;
    logic              pbit_q;
    logic [CNT_W-1:0]  nb_c;
    logic              par_en;

    // Format decode for this frame.
    always_comb begin
        nb_c   = CNT_W'(data_bits(len_code));
        par_en = par_on(par);
    end

    // Bit collection and character delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            pos_q    <= '0;
            dat_q    <= '0;
            pbit_q   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample_stb) begin
                if (!busy_q) begin
                    if (!ser_in_s) begin
                        busy_q <= 1'b1;
                        pos_q  <= '0;
                        dat_q  <= '0;
                    end
                end else if (pos_q < nb_c) begin
                    for (int i = 0; i < DATA_W; i++) begin
                        if (pos_q == CNT_W'(i)) dat_q[i] <= ser_in_s;
                    end
                    pos_q <= pos_q + CNT_W'(1);
                end else if (par_en && (pos_q == nb_c)) begin
                    pbit_q <= ser_in_s;
                    pos_q  <= pos_q + CNT_W'(1);
                end else begin
                    busy_q   <= 1'b0;
                    rx_valid <= 1'b1;
                    rx_data  <= dat_q;
                    rx_ferr  <= ~ser_in_s;
                    rx_perr  <= par_en & ((^dat_q) ^ pbit_q ^ (par == PAR_ODD));
                end
            end
        end
    end

    assign rx_busy = busy_q;

endmodule

// File: rtl/sync_frame_engine.sv
// Top of the synchronous character engine.
// Latches the format while both directions are idle and wires the edge
// strobes to the serializer and deserializer.
module sync_frame_engine
    import sfe_pkg::*;
#(
    parameter int DATA_W      = MAX_DATA,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    input  logic              cfg_pol,
    input  logic              ser_clk,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out,
    input  logic              ser_in,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr
);
    fmt_t fmt_q;
    logic launch_stb;
    logic sample_stb;
    logic ser_in_s;
    logic tx_busy;
    logic rx_busy;

    // Format register, updated only between frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_RESET;
        end else if (!tx_busy && !rx_busy) begin
            fmt_q <= '{len_code: cfg_len, par: par_e'(cfg_par),
                       stop2: cfg_stop2, pol: cfg_pol};
        end
    end

    sfe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_in     (ser_in),
        .pol        (fmt_q.pol),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb),
        .ser_in_s   (ser_in_s)
    );

    sfe_tx #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_code   (fmt_q.len_code),
        .par        (fmt_q.par),
        .stop2      (fmt_q.stop2),
        .launch_stb (launch_stb),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .ser_out    (ser_out),
        .tx_busy    (tx_busy)
    );

    sfe_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_code   (fmt_q.len_code),
        .par        (fmt_q.par),
        .sample_stb (sample_stb),
        .ser_in_s   (ser_in_s),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .rx_busy    (rx_busy)
    );

endmodule

// File: rtl/sfe_checker.sv
// Temporal checks for sync_frame_engine, attached by bind below.
module sfe_checker
    import sfe_pkg::*;
#(
    parameter int DATA_W = MAX_DATA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch_stb,
    input logic              sample_stb,
    input logic              ser_out,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_busy,
    input logic              rx_busy,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_perr,
    input fmt_t              fmt_q
);
    // R5: the line moves only on the cycle after a launch strobe.
    p_line_on_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out != $past(ser_out)) |-> $past(launch_stb));

    // R4: an idle transmitter holds the line high.
    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_out);

    // R6: delivery is a single-cycle pulse.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: delivery follows a sample strobe.
    p_valid_after_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sample_stb));

    // R6: bits above the configured length are zero.
    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> data_bits(fmt_q.len_code)) == '0));

    // R7: no parity error when parity is off.
    p_no_perr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_on(fmt_q.par)) |-> !rx_perr);

    // R9: an accepted character blocks further acceptance.
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R10: format frozen while any direction is busy.
    p_fmt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy || rx_busy) |=> $stable(fmt_q));

endmodule

bind sync_frame_engine sfe_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .ser_out    (ser_out),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_busy    (tx_busy),
    .rx_busy    (rx_busy),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_perr    (rx_perr),
    .fmt_q      (fmt_q)
);

// File: tb/sync_frame_engine_tb.sv
// Sweep of all formats in both polarities with loopback, plus driven
// receive frames for the error flags.
module sync_frame_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_len = 3'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_pol = 1'b0;
    logic       ser_clk = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       ser_out;
    logic       ser_in;
    logic       rx_valid;
    logic [8:0] rx_data;
    logic       rx_perr;
    logic       rx_ferr;

    logic       use_drv = 1'b0;
    logic       drv_bit = 1'b1;
    int         n_chk = 0;
    int         n_fail = 0;
    int         rx_cnt = 0;
    logic [10:0] rx_log [0:255];
    bit         done = 1'b0;

    assign ser_in = use_drv ? drv_bit : ser_out;

    sync_frame_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .cfg_pol(cfg_pol), .ser_clk(ser_clk),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .ser_out(ser_out), .ser_in(ser_in), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    always #4 clk = ~clk;

    initial begin
        #6;
        forever #32 ser_clk = ~ser_clk;
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_log[rx_cnt % 256] = {rx_perr, rx_ferr, rx_data};
            rx_cnt = rx_cnt + 1;
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    function automatic logic [12:0] mk_frame(input logic [8:0] d, input int nb,
                                             input logic [1:0] par, input bit st2);
        logic [12:0] f;
        logic        p;
        f = '1;
        f[0] = 1'b0;
        p = (par == 2'd3);
        for (int i = 0; i < nb; i++) begin
            f[i+1] = d[i];
            p = p ^ d[i];
        end
        if (par[1]) f[nb+1] = p;
        return f;
    endfunction

    function automatic int frame_len(input int nb, input logic [1:0] par, input bit st2);
        return 1 + nb + (par[1] ? 1 : 0) + (st2 ? 2 : 1);
    endfunction

    task automatic sample_edge();
        if (cfg_pol) @(posedge ser_clk);
        else @(negedge ser_clk);
    endtask

    task automatic launch_edge();
        if (cfg_pol) @(negedge ser_clk);
        else @(posedge ser_clk);
    endtask

    task automatic set_cfg(input int len, input int par, input bit st2, input bit pol);
        @(negedge clk);
        cfg_len = 3'(len);
        cfg_par = 2'(par);
        cfg_stop2 = st2;
        cfg_pol = pol;
        repeat (20) @(negedge clk);
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Reads n bits of ser_out from the next start bit on, compares to expv.
    task automatic watch(input logic [25:0] expv, input int n, input string req);
        logic [25:0] got;
        logic [25:0] m;
        bit          found;
        int          w;
        got = '1;
        m = '0;
        found = 1'b0;
        w = 0;
        while (!found && w < 80) begin
            sample_edge();
            if (ser_out == 1'b0) found = 1'b1;
            w++;
        end
        got[0] = ser_out;
        for (int i = 1; i < n; i++) begin
            sample_edge();
            got[i] = ser_out;
        end
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        chk(found && ((got & m) == (expv & m)), req, "tx frame bits",
            32'(got & m), 32'(expv & m));
    endtask

    task automatic send_rx(input logic [12:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            launch_edge();
            drv_bit = f[i];
        end
        launch_edge();
        drv_bit = 1'b1;
        sample_edge();
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk(ser_out == 1'b1, "R11", "idle line", 32'(ser_out), 1);
        chk(tx_ready == 1'b1, "R11", "tx_ready", 32'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R11", "rx_valid", 32'(rx_valid), 0);

        // R11 default 8N1: a frame sent before any format change.
        begin
            int base = rx_cnt;
            fork
                push(9'h1C3);
                watch(26'(mk_frame(9'h0C3, 8, 2'd0, 1'b0)), 10, "R11");
            join
            repeat (10) @(negedge clk);
            chk(rx_cnt == base + 1 && rx_log[base % 256] == 11'h0C3, "R11",
                "default format rx", 32'(rx_log[base % 256]), 32'h0C3);
        end

        // R1 R2 R3 R4 R5 R6: every format, both polarities, back-to-back pairs.
        for (int pol = 0; pol < 2; pol++) begin
            for (int len = 0; len < 5; len++) begin
                for (int pi = 0; pi < 3; pi++) begin
                    for (int st = 0; st < 2; st++) begin
                        logic [1:0]  par;
                        int          nb;
                        logic [8:0]  mask;
                        logic [8:0]  d0;
                        logic [8:0]  d1;
                        logic [12:0] f0;
                        logic [12:0] f1;
                        int          n0;
                        logic [25:0] ev;
                        int          base;
                        par = (pi == 0) ? 2'd0 : (pi == 1) ? 2'd2 : 2'd3;
                        nb = 5 + len;
                        mask = 9'((1 << nb) - 1);
                        d0 = 9'(9'h1A5 ^ 9'(len * 37 + pi * 11 + st * 5 + pol * 3)) & mask;
                        d1 = d0 ^ mask;
                        set_cfg(len, int'(par), st[0], pol[0]);
                        f0 = mk_frame(d0, nb, par, st[0]);
                        f1 = mk_frame(d1, nb, par, st[0]);
                        n0 = frame_len(nb, par, st[0]);
                        ev = '1;
                        for (int i = 0; i < n0; i++) ev[i] = f0[i];
                        for (int i = 0; i < n0; i++) ev[n0 + i] = f1[i];
                        base = rx_cnt;
                        fork
                            begin
                                push(d0 | ~mask);
                                push(d1);
                            end
                            watch(ev, 2 * n0, "R1 R2 R3 R4 R5 frames");
                        join
                        repeat (10) @(negedge clk);
                        chk(rx_cnt == base + 2, "R6", "rx pulse count",
                            32'(rx_cnt - base), 2);
                        chk(rx_log[base % 256] == {2'b00, d0}, "R6", "rx first char",
                            32'(rx_log[base % 256]), 32'(d0));
                        chk(rx_log[(base + 1) % 256] == {2'b00, d1}, "R6", "rx second char",
                            32'(rx_log[(base + 1) % 256]), 32'(d1));
                    end
                end
            end
        end

        // R4: after a lone frame the line stays high.
        set_cfg(1, 0, 1'b0, 1'b0);
        fork
            push(9'h015);
            watch(26'(mk_frame(9'h015, 6, 2'd0, 1'b0)), 8, "R4");
        join
        begin
            bit hi = 1'b1;
            for (int i = 0; i < 4; i++) begin
                sample_edge();
                if (ser_out !== 1'b1) hi = 1'b0;
            end
            chk(hi, "R4", "idle after frame", 32'(hi), 1);
        end

        // R9: ready drops right after acceptance.
        push(9'h0AA);
        chk(tx_ready == 1'b0, "R9", "ready after accept", 32'(tx_ready), 0);
        repeat (200) @(negedge clk);

        // R10: a format change mid-frame does not alter that frame.
        set_cfg(3, 0, 1'b0, 1'b0);
        fork
            push(9'h0C3);
            watch(26'(mk_frame(9'h0C3, 8, 2'd0, 1'b0)), 10, "R10");
            begin
                repeat (3) @(posedge ser_clk);
                cfg_len = 3'd0;
                cfg_par = 2'd2;
                cfg_stop2 = 1'b1;
            end
        join
        repeat (40) @(negedge clk);
        fork
            push(9'h01F);
            watch(26'(mk_frame(9'h01F, 5, 2'd2, 1'b1)), 9, "R10");
        join
        repeat (40) @(negedge clk);

        // R7 R8: driven receive frames, 8 bits even, polarity 1.
        set_cfg(3, 2, 1'b0, 1'b1);
        use_drv = 1'b1;
        begin
            logic [12:0] f;
            int base;
            f = mk_frame(9'h0A5, 8, 2'd2, 1'b0);
            f[9] = ~f[9];
            base = rx_cnt;
            send_rx(f, 10);
            chk(rx_cnt == base + 1 && rx_log[base % 256] == {2'b10, 9'h0A5}, "R7",
                "bad even parity", 32'(rx_log[base % 256]), 32'h4A5);
            f = mk_frame(9'h05A, 8, 2'd2, 1'b0);
            f[10] = 1'b0;
            base = rx_cnt;
            send_rx(f, 11);
            chk(rx_cnt == base + 1 && rx_log[base % 256] == {2'b01, 9'h05A}, "R8",
                "low stop bit", 32'(rx_log[base % 256]), 32'h25A);
        end
        set_cfg(3, 3, 1'b1, 1'b1);
        begin
            logic [12:0] f;
            int base;
            f = mk_frame(9'h03C, 8, 2'd3, 1'b1);
            base = rx_cnt;
            send_rx(f, 12);
            chk(rx_cnt == base + 1 && rx_log[base % 256] == {2'b00, 9'h03C}, "R7",
                "good odd parity", 32'(rx_log[base % 256]), 32'h03C);
            f[9] = ~f[9];
            base = rx_cnt;
            send_rx(f, 12);
            chk(rx_cnt == base + 1 && rx_log[base % 256] == {2'b10, 9'h03C}, "R7",
                "bad odd parity", 32'(rx_log[base % 256]), 32'h43C);
        end
        use_drv = 1'b0;

        done = 1'b1;
        report();
        $finish;
    end

endmodule